// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Flag Unit

This block watches sixteen general-purpose input pins, arranged as two groups of eight, and records a sticky flag for every pin that shows a transition of the polarity chosen for it. Each pin has three control bits: an enable bit, a polarity bit and the flag itself. The pins are first brought into the clock domain by a two-stage synchronizer. A change is then found by comparing the newest synchronized sample with the sample one cycle older.

Each group drives one level-sensitive request line toward an external interrupt controller. The line is high while any pin in that group has both its flag and its enable bit set. Flags latch even for pins whose enable bit is 0. Software therefore clears stale flags before it enables a pin, and it clears a flag after servicing it by writing a 1 to that bit. A small byte-wide register port gives access to the three registers of each group. Writes are synchronous and reads are combinational on the address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every enable, polarity and flag register reads 0 and both request lines are low.
- R2: With a pin's polarity bit at 0, a low-to-high transition on that pin sets its flag.
- R3: With a pin's polarity bit at 1, a high-to-low transition sets its flag. A transition of the other polarity leaves the flag unchanged, whatever the polarity setting.
- R4: When a pin changes just before clock edge k, its flag becomes visible after edge k+2. It is still 0 after edge k+1.
- R5: Writing a byte to a group's flag register clears each flag whose bit in the byte is 1. Bits written as 0 leave their flags unchanged.
- R6: A flag is set by a qualifying edge even while its enable bit is 0. While a group's enable register is 0, that group's request line stays low.
- R7: Request line g equals the OR over that group's eight pins of (flag AND enable). It rises in the same cycle the flag becomes visible and stays high until the flag or the enable bit is cleared.
- R8: If a qualifying edge and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R9: Register map: group g has base address 0x10*g. The enable register is at base+5, the polarity register at base+6 and the flag register at base+7. Enable and polarity read back what was written. Any other address reads 0 and ignores writes.
- R10: Pins 0 to 7 belong to group 0 and request line bit 0. Pins 8 to 15 belong to group 1 and request line bit 1. Bit i of a group's registers maps to pin 8*g+i. Activity in one group does not change the other group's registers or request line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw pin levels, asynchronous to clk |
| reg_we | input | 1 | Register write strobe, taken at the rising clock edge |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_o | output | 2 | Per-group level interrupt request |

## Verification
The assertions check the flag invariants on every cycle. A detected edge always leaves its flag set on the next cycle, even when a clear lands at the same time. A flag only rises when an edge was detected, and it only falls where a 1 was written to clear it. A request line is never high while its enable register is 0 or while its group has no flag set. The register map, the polarity choice, the exact three-edge latency from pin to flag, the masked-then-enabled sequence and the independence of the two groups can only be shown by the bench's directed scenarios.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ENA_OFS = 5;
  localparam int unsigned POL_OFS = 6;
  localparam int unsigned FLG_OFS = 7;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ENA  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_FLG  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int unsigned ofs);
    case (ofs)
      ENA_OFS: return SEL_ENA;
      POL_OFS: return SEL_POL;
      FLG_OFS: return SEL_FLG;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_o  <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= raw_i;
      cur_o  <= meta_q;
      prev_o <= cur_o;
    end
  end

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] cur_i,
  input  logic [PINS-1:0] prev_i,
  input  logic            ena_we,
  input  logic            pol_we,
  input  logic            flg_we,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] ena_q,
  output logic [PINS-1:0] pol_q,
  output logic [PINS-1:0] flg_q,
  output logic            irq_o
);

  // Per-bit edge qualification: pol=0 rising, pol=1 falling
  function automatic logic [PINS-1:0] edge_hit(
    input logic [PINS-1:0] cur,
    input logic [PINS-1:0] prev,
    input logic [PINS-1:0] pol
  );
    return (cur & ~prev & ~pol) | (~cur & prev & pol);
  endfunction

  logic [PINS-1:0] hit;
  logic [PINS-1:0] clr;
  logic [PINS-1:0] flg_next;

  assign hit      = edge_hit(cur_i, prev_i, pol_q);
  assign clr      = flg_we ? wdata : '0;
  assign flg_next = (flg_q & ~clr) | hit;
  assign irq_o    = |(flg_q & ena_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      pol_q <= '0;
      flg_q <= '0;
    end else begin
      if (ena_we) ena_q <= wdata;
      if (pol_we) pol_q <= wdata;
      flg_q <= flg_next;
    end
  end

  // R8
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flg_q & $past(hit)) == $past(hit)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg_q & ~$past(flg_q) & ~$past(hit)) == '0));

  // R5
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flg_q & $past(flg_q) & ~$past(clr)) == '0));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq_o);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned GROUPS       = 2,
  parameter int unsigned PINS         = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned GROUP_STRIDE = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GROUPS*PINS-1:0]   pin_i,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [PINS-1:0]          reg_wdata,
  output logic [PINS-1:0]          reg_rdata,
  output logic [GROUPS-1:0]        irq_o
);
  import gpio_irq_pkg::*;

  localparam int unsigned NPIN  = GROUPS * PINS;
  localparam int unsigned OFS_W = $clog2(GROUP_STRIDE);
  localparam int unsigned SEL_W = ADDR_W - OFS_W;

  logic [NPIN-1:0] cur_s;
  logic [NPIN-1:0] prev_s;
  logic [PINS-1:0] ena_arr [GROUPS];
  logic [PINS-1:0] pol_arr [GROUPS];
  logic [PINS-1:0] flg_arr [GROUPS];
  logic [GROUPS-1:0] grp_hit;
  reg_sel_e          sel;

  assign sel = decode_ofs(int'(reg_addr[OFS_W-1:0]));

  gpio_pin_sync #(.W(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_i),
    .cur_o  (cur_s),
    .prev_o (prev_s)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_hit[g] = (reg_addr[ADDR_W-1:OFS_W] == SEL_W'(g));

    gpio_irq_group #(.PINS(PINS)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_i  (cur_s[g*PINS +: PINS]),
      .prev_i (prev_s[g*PINS +: PINS]),
      .ena_we (reg_we && grp_hit[g] && sel == SEL_ENA),
      .pol_we (reg_we && grp_hit[g] && sel == SEL_POL),
      .flg_we (reg_we && grp_hit[g] && sel == SEL_FLG),
      .wdata  (reg_wdata),
      .ena_q  (ena_arr[g]),
      .pol_q  (pol_arr[g]),
      .flg_q  (flg_arr[g]),
      .irq_o  (irq_o[g])
    );

    // R7
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> (flg_arr[g] != '0));
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < int'(GROUPS); g++) begin
      if (grp_hit[g]) begin
        case (sel)
          SEL_ENA: reg_rdata = ena_arr[g];
          SEL_POL: reg_rdata = pol_arr[g];
          SEL_FLG: reg_rdata = flg_arr[g];
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  // R9
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE || grp_hit == '0) |-> (reg_rdata == '0));

endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin),
    .reg_we    (we),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq_o     (irq)
  );

  // Address helpers from the map: base 0x10*g, +5 enable, +6 polarity, +7 flags
  function automatic logic [7:0] a_ena(input int g); return 8'(16*g + 5); endfunction
  function automatic logic [7:0] a_pol(input int g); return 8'(16*g + 6); endfunction
  function automatic logic [7:0] a_flg(input int g); return 8'(16*g + 7); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Drive one pin at a falling edge, then wait the three rising edges to the flag
  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin[idx] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int g = 0; g < 2; g++) begin
      rd(a_ena(g), d); chk("R1 enable reset", d, 0);
      rd(a_pol(g), d); chk("R1 polarity reset", d, 0);
      rd(a_flg(g), d); chk("R1 flag reset", d, 0);
    end
    chk("R1 irq reset", irq, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(a_ena(0), 8'hA5); rd(a_ena(0), d); chk("R9 enable readback", d, 8'hA5);
    wr(a_pol(1), 8'h3C); rd(a_pol(1), d); chk("R9 polarity readback", d, 8'h3C);
    wr(8'h08, 8'hFF);    rd(8'h08, d);    chk("R9 unmapped offset reads 0", d, 0);
    wr(8'h25, 8'hFF);    rd(8'h25, d);    chk("R9 absent group reads 0", d, 0);
    rd(a_ena(0), d); chk("R9 enable untouched by stray writes", d, 8'hA5);
    rd(a_pol(1), d); chk("R9 polarity untouched by stray writes", d, 8'h3C);
    wr(a_ena(0), 8'h00);
    wr(a_pol(1), 8'h00);
  endtask

  task automatic t_rising();
    logic [7:0] d;
    @(negedge clk);
    pin[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = a_flg(0); #1;
    chk("R4 flag not yet set after two edges", rdata, 0);
    @(posedge clk);
    @(negedge clk);
    addr = a_flg(0); #1;
    chk("R2 R4 rising edge sets flag on third edge", rdata, 8'h01);
    set_pin(0, 1'b0);
    rd(a_flg(0), d); chk("R3 falling edge ignored with polarity 0", d, 8'h01);
    wr(a_flg(0), 8'hFE);
    rd(a_flg(0), d); chk("R5 writing 0 keeps flag", d, 8'h01);
    wr(a_flg(0), 8'h01);
    rd(a_flg(0), d); chk("R5 writing 1 clears flag", d, 8'h00);
  endtask

  task automatic t_falling();
    logic [7:0] d;
    wr(a_pol(0), 8'h02);
    set_pin(1, 1'b1);
    rd(a_flg(0), d); chk("R3 rising edge ignored with polarity 1", d, 8'h00);
    set_pin(1, 1'b0);
    rd(a_flg(0), d); chk("R3 falling edge sets flag", d, 8'h02);
    wr(a_flg(0), 8'h02);
    wr(a_pol(0), 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    set_pin(2, 1'b1);
    rd(a_flg(0), d); chk("R6 flag sets while masked", d, 8'h04);
    chk("R6 irq low while masked", irq, 2'b00);
    wr(a_ena(0), 8'h04);
    #1; chk("R7 enabling a stale flag raises irq", irq, 2'b01);
    wr(a_flg(0), 8'h04);
    #1; chk("R7 clearing the flag drops irq", irq, 2'b00);
    wr(a_ena(0), 8'h00);
    set_pin(2, 1'b0);
  endtask

  task automatic t_enabled();
    wr(a_ena(0), 8'h08);
    @(negedge clk);
    pin[3] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 irq low before flag visible", irq, 2'b00);
    @(posedge clk);
    @(negedge clk);
    chk("R7 irq rises with flag", irq, 2'b01);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 irq held while flag set", irq, 2'b01);
    wr(a_flg(0), 8'h08);
    #1; chk("R7 irq drops after clear", irq, 2'b00);
    wr(a_ena(0), 8'h00);
  endtask

  task automatic t_group1();
    logic [7:0] d;
    wr(a_ena(1), 8'hFF);
    set_pin(12, 1'b1);
    rd(a_flg(1), d); chk("R10 pin 12 maps to group 1 bit 4", d, 8'h10);
    rd(a_flg(0), d); chk("R10 group 0 flags untouched", d, 8'h00);
    chk("R10 only irq bit 1 raised", irq, 2'b10);
    wr(a_flg(1), 8'h10);
    #1; chk("R10 group 1 irq cleared", irq, 2'b00);
    wr(a_ena(1), 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    set_pin(5, 1'b1);
    set_pin(5, 1'b0);
    rd(a_flg(0), d); chk("R8 flag preset", d, 8'h20);
    @(negedge clk);
    pin[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    we = 1'b1; addr = a_flg(0); wdata = 8'h20;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    rd(a_flg(0), d); chk("R8 set wins over same-cycle clear", d, 8'h20);
    wr(a_flg(0), 8'h20);
    rd(a_flg(0), d); chk("R8 later clear takes effect", d, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_rising();
    t_falling();
    t_masked();
    t_enabled();
    t_group1();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule